// File: doc/BRIEF.md
# Parallel Symbol Slicer with Path-Metric Update

This block takes a group of four sibling-level tree nodes per beat and, for each one, picks the closest 16-QAM child symbol. It then extends the parent's accumulated metric by that child's squared error. For each node it receives the complex interference-cancelled value b, the node's parent metric, and one real positive diagonal gain R shared by the whole group, since all four nodes sit on the same tree level. The closest symbol is found without computing a metric for every candidate. Each axis of b is compared against 0 and against plus and minus twice R, and the real and imaginary components are decided independently. Every sibling shares the same parent metric, so the smallest error magnitude is also the smallest child metric.

With the chosen symbol the lane forms e = b - R*s and squares both components. It adds them to the parent metric, and the sum is clamped at the largest representable value instead of wrapping. When a level is expanded in full, a group-wide control pin replaces each lane's decision with a per-lane symbol index. The traversal controller uses this to step through all sixteen children.

Data enters and leaves through valid/ready handshakes with one register stage between them. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being emptied in the same cycle. An output beat stays unchanged while `out_valid` is high and `out_ready` is low.

Top module: `node_ped_slicer`

## Requirements
- R1: Per axis, with x the axis component of b and the index encoding 0=-3, 1=-1, 2=+1, 3=+3, the decision is: x < -2R gives 0; -2R <= x < 0 gives 1; 0 <= x < 2R gives 2; x >= 2R gives 3. A value exactly on a boundary takes the upper symbol. The real-axis index sits in bits [3:2] of a lane's 4-bit symbol field and the imaginary-axis index in bits [1:0].
- R2: When `full_expand` is high on an accepted beat, each lane outputs its `force_idx` field unchanged in place of the slicer decision, and the metric is computed for that forced symbol. When `full_expand` is low, `force_idx` has no effect on any output.
- R3: Each lane's `d_child` equals `d_parent + (b_re - R*s_re)^2 + (b_im - R*s_im)^2`, where s is the output symbol's level.
- R4: If that sum exceeds 2^D_W-1, `d_child` is 2^D_W-1.
- R5: An accepted beat appears on the output on the next cycle. An output beat is held stable until `out_ready` is high, and no beat is lost or duplicated under back-pressure.
- R6: After reset `out_valid` is low and `in_ready` is high. With `in_ready` high and `in_valid` low, `out_valid` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| full_expand | input | 1 | Replace slicer decisions with `force_idx` |
| force_idx | input | LANES*4 | Per-lane forced symbol index, {re[1:0], im[1:0]} |
| r_diag | input | R_W | Unsigned diagonal gain shared by the group |
| b_re | input | LANES*B_W | Signed real part of b, per lane |
| b_im | input | LANES*B_W | Signed imaginary part of b, per lane |
| d_parent | input | LANES*D_W | Unsigned parent metric, per lane |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| sym_idx | output | LANES*4 | Chosen symbol index per lane, {re, im} |
| d_child | output | LANES*D_W | Saturated child metric per lane |

## Verification
The hardest cases to reach are the exact boundary values and the clamp. Random values of b rarely land on 0 or on plus or minus 2R, and parent metrics drawn at random seldom come close enough to the ceiling to overflow. Directed beats therefore place b exactly on each threshold and one unit either side, and use R=0 to collapse the thresholds. They also drive parent metrics of full scale and one below full scale. Random traffic runs under random `out_ready` stalls to exercise the hold rules.

// File: rtl/ped_slicer_pkg.sv
package ped_slicer_pkg;
  typedef logic [1:0] axis_idx_t;

  localparam axis_idx_t AX_M3 = 2'd0;
  localparam axis_idx_t AX_M1 = 2'd1;
  localparam axis_idx_t AX_P1 = 2'd2;
  localparam axis_idx_t AX_P3 = 2'd3;

  localparam int SYM_W = 4;
endpackage

// File: rtl/axis_slicer.sv
module axis_slicer
  import ped_slicer_pkg::*;
#(
  parameter int B_W = 12,
  parameter int R_W = 11
) (
  input  logic signed [B_W-1:0] x,
  input  logic        [R_W-1:0] r,
  output axis_idx_t             idx
);
  localparam int C_W = ((B_W > R_W + 1) ? B_W : R_W + 1) + 1;

  logic signed [C_W-1:0] xw;
  logic signed [C_W-1:0] thr;

  assign xw  = {{(C_W-B_W){x[B_W-1]}}, x};
  assign thr = {{(C_W-R_W-1){1'b0}}, r, 1'b0};

  // boundaries at 0 and +/-2R; equality resolves upward
  always_comb begin
    if (xw >= thr)            idx = AX_P3;
    else if (!xw[C_W-1])      idx = AX_P1;
    else if (xw >= -thr)      idx = AX_M1;
    else                      idx = AX_M3;
  end
endmodule

// File: rtl/ped_lane.sv
module ped_lane
  import ped_slicer_pkg::*;
#(
  parameter int B_W = 12,
  parameter int R_W = 11,
  parameter int D_W = 18
) (
  input  logic signed [B_W-1:0]   b_re,
  input  logic signed [B_W-1:0]   b_im,
  input  logic        [R_W-1:0]   r,
  input  logic        [D_W-1:0]   d_par,
  input  logic                    force_en,
  input  logic        [SYM_W-1:0] force_sym,
  output logic        [SYM_W-1:0] sym,
  output logic        [D_W-1:0]   d_out
);
  localparam int E_W  = ((B_W > R_W + 2) ? B_W : R_W + 2) + 2;
  localparam int SQ_W = 2 * E_W;
  localparam int S_W  = ((SQ_W > D_W) ? SQ_W : D_W) + 2;

  axis_idx_t slice_re, slice_im;
  axis_idx_t pick_re, pick_im;

  axis_slicer #(.B_W(B_W), .R_W(R_W)) u_sl_re (.x(b_re), .r(r), .idx(slice_re));
  axis_slicer #(.B_W(B_W), .R_W(R_W)) u_sl_im (.x(b_im), .r(r), .idx(slice_im));

  assign sym     = force_en ? force_sym : {slice_re, slice_im};
  assign pick_re = sym[3:2];
  assign pick_im = sym[1:0];

  logic signed [E_W-1:0] r_one, r_three;
  assign r_one   = {{(E_W-R_W){1'b0}}, r};
  assign r_three = r_one + (r_one <<< 1);

  function automatic logic signed [E_W-1:0] scaled(axis_idx_t k,
                                                   logic signed [E_W-1:0] one,
                                                   logic signed [E_W-1:0] three);
    case (k)
      AX_M3:   scaled = -three;
      AX_M1:   scaled = -one;
      AX_P1:   scaled = one;
      default: scaled = three;
    endcase
  endfunction

  logic signed [E_W-1:0]  e_re, e_im;
  logic signed [SQ_W-1:0] sq_re, sq_im;
  logic        [S_W-1:0]  sum;

  assign e_re  = {{(E_W-B_W){b_re[B_W-1]}}, b_re} - scaled(pick_re, r_one, r_three);
  assign e_im  = {{(E_W-B_W){b_im[B_W-1]}}, b_im} - scaled(pick_im, r_one, r_three);
  assign sq_re = e_re * e_re;
  assign sq_im = e_im * e_im;

  assign sum = {{(S_W-D_W){1'b0}}, d_par}
             + {{(S_W-SQ_W){1'b0}}, sq_re}
             + {{(S_W-SQ_W){1'b0}}, sq_im};

  assign d_out = (sum > {{(S_W-D_W){1'b0}}, {D_W{1'b1}}}) ? {D_W{1'b1}} : sum[D_W-1:0];
endmodule

// File: rtl/node_ped_slicer.sv
module node_ped_slicer
  import ped_slicer_pkg::*;
#(
  parameter int LANES = 4,
  parameter int B_W   = 12,
  parameter int R_W   = 11,
  parameter int D_W   = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   full_expand,
  input  logic [LANES*SYM_W-1:0] force_idx,
  input  logic [R_W-1:0]         r_diag,
  input  logic [LANES*B_W-1:0]   b_re,
  input  logic [LANES*B_W-1:0]   b_im,
  input  logic [LANES*D_W-1:0]   d_parent,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*SYM_W-1:0] sym_idx,
  output logic [LANES*D_W-1:0]   d_child
);
  logic [LANES*SYM_W-1:0] sym_nxt;
  logic [LANES*D_W-1:0]   d_nxt;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ped_lane #(.B_W(B_W), .R_W(R_W), .D_W(D_W)) u_lane (
      .b_re      (b_re[l*B_W +: B_W]),
      .b_im      (b_im[l*B_W +: B_W]),
      .r         (r_diag),
      .d_par     (d_parent[l*D_W +: D_W]),
      .force_en  (full_expand),
      .force_sym (force_idx[l*SYM_W +: SYM_W]),
      .sym       (sym_nxt[l*SYM_W +: SYM_W]),
      .d_out     (d_nxt[l*D_W +: D_W])
    );
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sym_idx   <= '0;
      d_child   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        sym_idx <= sym_nxt;
        d_child <= d_nxt;
      end
    end
  end
endmodule

// File: rtl/node_ped_slicer_chk.sv
module node_ped_slicer_chk #(
  parameter int LANES = 4,
  parameter int B_W   = 12,
  parameter int R_W   = 11,
  parameter int D_W   = 18
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 full_expand,
  input logic [LANES*4-1:0]   force_idx,
  input logic [R_W-1:0]       r_diag,
  input logic [LANES*B_W-1:0] b_re,
  input logic [LANES*B_W-1:0] b_im,
  input logic [LANES*D_W-1:0] d_parent,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [LANES*4-1:0]   sym_idx,
  input logic [LANES*D_W-1:0] d_child
);
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(sym_idx) && $stable(d_child));

  p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && in_ready |=> !out_valid);

  p_force_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && full_expand |=> sym_idx == $past(force_idx));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    p_ped_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> d_child[l*D_W +: D_W] >= $past(d_parent[l*D_W +: D_W]));

    p_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && (d_parent[l*D_W +: D_W] == {D_W{1'b1}})
      |=> d_child[l*D_W +: D_W] == {D_W{1'b1}});
  end
endmodule

bind node_ped_slicer node_ped_slicer_chk #(
  .LANES(LANES), .B_W(B_W), .R_W(R_W), .D_W(D_W)
) chk_i (.*);

// File: tb/node_ped_slicer_tb_top.sv
module node_ped_slicer_tb_top;
  localparam int LANES = 4;
  localparam int B_W   = 12;
  localparam int R_W   = 11;
  localparam int D_W   = 18;
  localparam longint DMAX = (longint'(1) << D_W) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic                 full_expand = 1'b0;
  logic [LANES*4-1:0]   force_idx = '0;
  logic [R_W-1:0]       r_diag = '0;
  logic [LANES*B_W-1:0] b_re = '0;
  logic [LANES*B_W-1:0] b_im = '0;
  logic [LANES*D_W-1:0] d_parent = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic [LANES*4-1:0]   sym_idx;
  logic [LANES*D_W-1:0] d_child;

  always #5 clk = ~clk;

  node_ped_slicer #(.LANES(LANES), .B_W(B_W), .R_W(R_W), .D_W(D_W)) dut_i (.*);

  typedef struct {
    logic [LANES*4-1:0]   sym;
    logic [LANES*D_W-1:0] d;
    string                tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   stall_mode = 1'b0;
  bit   done = 1'b0;

  function automatic int slice(int x, int r);
    if (x >= 2 * r)  return 3;
    if (x >= 0)      return 2;
    if (x >= -2 * r) return 1;
    return 0;
  endfunction

  function automatic longint lane_ped(int bre, int bim, int r, longint d, int sre, int sim);
    longint er, ei, s;
    er = longint'(bre) - longint'(r) * longint'(2 * sre - 3);
    ei = longint'(bim) - longint'(r) * longint'(2 * sim - 3);
    s  = d + er * er + ei * ei;
    return (s > DMAX) ? DMAX : s;
  endfunction

  // build expected beat from current inputs and push it when accepted
  task automatic send(string tag);
    exp_t e;
    for (int l = 0; l < LANES; l++) begin
      int bre, bim, sre, sim;
      bre = int'($signed(b_re[l*B_W +: B_W]));
      bim = int'($signed(b_im[l*B_W +: B_W]));
      if (full_expand) begin
        sre = int'(force_idx[l*4+2 +: 2]);
        sim = int'(force_idx[l*4 +: 2]);
      end else begin
        sre = slice(bre, int'(r_diag));
        sim = slice(bim, int'(r_diag));
      end
      e.sym[l*4 +: 4]     = {2'(sre), 2'(sim)};
      e.d[l*D_W +: D_W]   = D_W'(lane_ped(bre, bim, int'(r_diag),
                                 longint'(d_parent[l*D_W +: D_W]), sre, sim));
    end
    e.tag = tag;
    in_valid = 1'b1;
    forever begin
      #1;
      if (in_ready) begin
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic set_lane(int l, int bre, int bim, longint d, int fidx);
    b_re[l*B_W +: B_W]   = B_W'(bre);
    b_im[l*B_W +: B_W]   = B_W'(bim);
    d_parent[l*D_W +: D_W] = D_W'(d);
    force_idx[l*4 +: 4]  = 4'(fidx);
  endtask

  // back-pressure source
  always @(negedge clk) out_ready <= stall_mode ? 1'($urandom % 2) : 1'b1;

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          fails++; checks++;
          $display("FAIL R5 unexpected output beat sym=%h d=%h expected none", sym_idx, d_child);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          for (int l = 0; l < LANES; l++) begin
            checks++;
            if (sym_idx[l*4 +: 4] !== e.sym[l*4 +: 4] || d_child[l*D_W +: D_W] !== e.d[l*D_W +: D_W]) begin
              fails++;
              $display("FAIL %s lane %0d sym=%h d=%0d expected sym=%h d=%0d", e.tag, l,
                       sym_idx[l*4 +: 4], d_child[l*D_W +: D_W], e.sym[l*4 +: 4], e.d[l*D_W +: D_W]);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired with %0d beats pending", exp_q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R6 after reset out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 boundaries around -2R and 0 (R=100)
    r_diag = 11'd100; full_expand = 1'b0;
    set_lane(0, -201, 199, 10, 0);
    set_lane(1, -200, 200, 0, 0);
    set_lane(2, -1, 1, 5, 0);
    set_lane(3, 0, -300, 7, 0);
    send("R1");
    set_lane(0, 201, -199, 0, 0);
    set_lane(1, -2048, 2047, 0, 0);
    set_lane(2, 1, -1, 0, 0);
    set_lane(3, 200, -200, 0, 0);
    send("R1");
    // R1 with R=0: all thresholds collapse to zero
    r_diag = 11'd0;
    set_lane(0, 0, -1, 3, 0);
    set_lane(1, -1, 0, 3, 0);
    set_lane(2, 5, -5, 3, 0);
    set_lane(3, -2048, 2047, 3, 0);
    send("R1");

    // R2 forced symbols, then force_idx ignored when full_expand low
    r_diag = 11'd300;
    full_expand = 1'b1;
    set_lane(0, 900, 900, 100, 4'b0000);
    set_lane(1, 900, 900, 100, 4'b0110);
    set_lane(2, -50, 20, 100, 4'b1011);
    set_lane(3, 0, 0, 100, 4'b1111);
    send("R2");
    full_expand = 1'b0;
    send("R2");

    // R3 exact metric (nonzero residuals)
    r_diag = 11'd257;
    set_lane(0, 300, -700, 1000, 0);
    set_lane(1, -1000, 13, 0, 0);
    set_lane(2, 777, 777, 40000, 0);
    set_lane(3, -5, 600, 123456, 0);
    send("R3");

    // R4 clamp: full-scale parent, parent one below max, huge residual
    r_diag = 11'd2047;
    set_lane(0, 1, 0, DMAX, 0);
    set_lane(1, 5, 5, DMAX - 1, 0);
    set_lane(2, 2047, -2048, 0, 0);
    set_lane(3, 2000, 2000, DMAX - 1, 0);
    send("R4");
    full_expand = 1'b1;
    r_diag = 11'd1500;
    set_lane(0, -2048, -2048, 0, 4'b1111);
    set_lane(1, 0, 0, DMAX, 4'b0000);
    set_lane(2, 0, 0, 0, 4'b0101);
    set_lane(3, 0, 0, 0, 4'b1010);
    send("R4");
    full_expand = 1'b0;

    // R5 back-to-back under random stalls, mixed random traffic (R1/R3)
    stall_mode = 1'b1;
    for (int n = 0; n < 300; n++) begin
      r_diag = R_W'($urandom % 1024);
      full_expand = ($urandom % 5) == 0;
      for (int l = 0; l < LANES; l++)
        set_lane(l, int'($urandom % 4096) - 2048, int'($urandom % 4096) - 2048,
                 longint'($urandom % (1 << D_W)), int'($urandom % 16));
      send("R5");
    end
    stall_mode = 1'b0;
    full_expand = 1'b0;

    // R6 idle: no new beat appears without input
    repeat (4) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || exp_q.size() != 0) begin
      fails++;
      $display("FAIL R6 idle out_valid=%b pending=%0d expected 0 0", out_valid, exp_q.size());
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule